// File: doc/BRIEF.md
# Host/System Mailbox Controller

This block carries requests from a system-side requester to a host-side responder. The requester streams 32-bit words into an inbound buffer that lives in memory. Each word lands at a write pointer that climbs from a host-programmed base toward a host-programmed limit. The requester signals that a request is complete with a "go" command, and can cancel a request with an "abort" command. The host sees these events as interrupt sources. It acknowledges an abort, reports a finished response, and can flag an error on purpose.

Three causes run one shared error procedure: an inbound word pushed at or past the limit, a memory write that reports an error, and the host writing the error bit. The procedure sets the error flag. It sets the system-interrupt status if the system interrupt is enabled. It raises the host error interrupt. A failed memory write also pulses a recoverable alert. The system side reads a status word whose interrupt field reflects the system-interrupt status, not the busy flag.

Register accesses take effect at the clock edge, and read data is combinational from the current state. The memory write is issued combinationally during the push cycle, and its error response is sampled in the same cycle.

Top module: `mbx_ctrl`

## Requirements
- R1: After reset, all host registers (word indices 0..7) read 0, the system status reads 0, and host_irq, alert_recov and m_wr_en are 0.
- R2: Host interrupt state bits are 0 = ready, 1 = abort, 2 = error. host_irq is the OR over these bits of (state AND enable), where enable is host index 1. Writing 1 to a bit of index 0 clears that state bit. Writing 1 to a bit of index 2 (test) sets it.
- R3: A system write of bit 1 to its control register (index 1, "go") sets busy (host status bit 0) and interrupt state bit 0, and clears ready.
- R4: A system write of bit 0 to its control register sets the abort flag (host control bit 0) and interrupt state bit 1. A host write of 1 to host control bit 0 clears both abort and busy, and also clears the error flag.
- R5: A host write of 1 to host control bit 1 runs the error procedure. This sets host control bit 1 and interrupt state bit 2.
- R6: The error procedure and response completion set the system-interrupt status (host status bit 1) only when the system-interrupt enable (host status bit 2, read/write) is 1.
- R7: A host write of 1 to host control bit 2 (response done) clears busy and sets ready (host status bit 3).
- R8: The system status register (system index 0) reads busy at bit 0, system-interrupt status at bit 1, error at bit 2 and ready at bit 3.
- R9: A push (system write to index 2) with write pointer < limit writes the data to memory at the write pointer. The pointer then advances by 4 if the memory reports no error.
- R10: A push with write pointer >= limit issues no memory write, leaves the pointer unchanged and runs the error procedure.
- R11: A push whose memory write returns an error runs the error procedure. It leaves the pointer unchanged and drives alert_recov high for exactly the one following cycle.
- R12: While the error flag is set, pushes are dropped: no memory write and no pointer change.
- R13: A host write to the inbound base (index 5) sets the base and resets the write pointer (index 7, read-only) to it. The limit is at index 6.
- R14: The system-interrupt status is cleared by a host write of 1 to host status bit 1, or by a system write of 1 to system status bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_req | input | 1 | Host register access strobe |
| h_we | input | 1 | Host write enable |
| h_addr | input | 3 | Host register word index |
| h_wdata | input | DW | Host write data |
| h_rdata | output | DW | Host read data (combinational) |
| s_req | input | 1 | System register access strobe |
| s_we | input | 1 | System write enable |
| s_addr | input | 2 | System register word index |
| s_wdata | input | DW | System write data |
| s_rdata | output | DW | System read data (combinational) |
| m_wr_en | output | 1 | Memory write request for an inbound word |
| m_wr_addr | output | AW | Memory write byte address |
| m_wr_data | output | DW | Memory write data |
| m_wr_err | input | 1 | Memory write error response, same cycle as m_wr_en |
| host_irq | output | 1 | Host interrupt line |
| alert_recov | output | 1 | Recoverable alert, one-cycle pulse |

## Verification
A wrong flag or pointer shows up at the ports one clock after the access that caused it. It appears either in host or system register reads, or as a memory write at the wrong address, or as one that should not be issued. A stuck or missed error flag appears in the very next push: it wrongly writes memory or wrongly drops the word. A gating slip in the error procedure shows as a system status interrupt bit that disagrees with the enable bit in the same read. Sweeps over every enable/state pair and over limits of zero to four words expose off-by-one limit checks and mask errors immediately.

// File: rtl/mbx_pkg.sv
// Shared register indices and bit positions for the mailbox controller.
// Assumes word-indexed register ports on both sides.
package mbx_pkg;

    localparam int unsigned N_IRQ     = 3;
    localparam int unsigned IRQ_READY = 0;
    localparam int unsigned IRQ_ABORT = 1;
    localparam int unsigned IRQ_ERROR = 2;

    // host register word indices
    typedef enum logic [2:0] {
        H_ISTATE  = 3'd0,
        H_IEN     = 3'd1,
        H_ITEST   = 3'd2,
        H_CTRL    = 3'd3,
        H_STATUS  = 3'd4,
        H_INBASE  = 3'd5,
        H_INLIMIT = 3'd6,
        H_INWPTR  = 3'd7
    } host_reg_e;

    // system register word indices
    typedef enum logic [1:0] {
        S_STATUS = 2'd0,
        S_CTRL   = 2'd1,
        S_WDATA  = 2'd2,
        S_RSVD   = 2'd3
    } sys_reg_e;

    // host control bits
    localparam int unsigned HC_ABORT = 0;
    localparam int unsigned HC_ERROR = 1;
    localparam int unsigned HC_DONE  = 2;

    // host status bits
    localparam int unsigned HS_BUSY  = 0;
    localparam int unsigned HS_SIS   = 1;
    localparam int unsigned HS_SIE   = 2;
    localparam int unsigned HS_READY = 3;

    // system status bits
    localparam int unsigned SS_BUSY  = 0;
    localparam int unsigned SS_INTR  = 1;
    localparam int unsigned SS_ERROR = 2;
    localparam int unsigned SS_READY = 3;

    // system control bits
    localparam int unsigned SC_ABORT = 0;
    localparam int unsigned SC_GO    = 1;

endpackage

// File: rtl/mbx_inbound.sv
// Inbound write path: holds base, limit and write pointer, and issues the
// memory write for each pushed word. It flags an overflow when the pointer
// has reached the limit and a memory error when the write is refused.
// Assumes the memory answers m_wr_err in the same cycle as m_wr_en.
module mbx_inbound #(
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_we,
    input  logic          limit_we,
    input  logic [AW-1:0] cfg_wd,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          drop,
    output logic          m_wr_en,
    output logic [AW-1:0] m_wr_addr,
    output logic [DW-1:0] m_wr_data,
    input  logic          m_wr_err,
    output logic [AW-1:0] base_q,
    output logic [AW-1:0] limit_q,
    output logic [AW-1:0] wptr_q,
    output logic          ovf_evt,
    output logic          merr_evt
);

    localparam logic [AW-1:0] STEP_A = AW'(STEP);

    logic room;
    logic live;
    logic wr_ok;

    assign room      = wptr_q < limit_q;
    assign live      = push & ~drop;
    assign m_wr_en   = live & room;
    assign m_wr_addr = wptr_q;
    assign m_wr_data = push_data;
    assign ovf_evt   = live & ~room;
    assign merr_evt  = m_wr_en & m_wr_err;
    assign wr_ok     = m_wr_en & ~m_wr_err;

    // base register, written by the host
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (base_we) base_q <= cfg_wd;
    end

    // limit register, written by the host
    always_ff @(posedge clk) begin
        if (!rst_n)        limit_q <= '0;
        else if (limit_we) limit_q <= cfg_wd;
    end

    // write pointer: reloads on a base write, steps on an accepted word
    always_ff @(posedge clk) begin
        if (!rst_n)       wptr_q <= '0;
        else if (base_we) wptr_q <= cfg_wd;
        else if (wr_ok)   wptr_q <= wptr_q + STEP_A;
    end

endmodule

// File: rtl/mbx_flags.sv
// Mailbox flags and interrupts: busy, abort, error, ready, the system
// interrupt status and enable, and the host interrupt state and enable.
// All error causes share one error procedure. Assumes the event inputs are
// single-cycle strobes already decoded from the register ports.
module mbx_flags
    import mbx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] istate_clr,
    input  logic [N_IRQ-1:0] istate_tst,
    input  logic             ien_we,
    input  logic [N_IRQ-1:0] ien_wd,
    input  logic             abort_ack,
    input  logic             err_set_sw,
    input  logic             resp_done,
    input  logic             sie_we,
    input  logic             sie_wd,
    input  logic             sis_clr,
    input  logic             req_go,
    input  logic             req_abort,
    input  logic             ovf_evt,
    input  logic             merr_evt,
    output logic             busy_q,
    output logic             abort_q,
    output logic             err_q,
    output logic             ready_q,
    output logic             sis_q,
    output logic             sie_q,
    output logic [N_IRQ-1:0] istate_q,
    output logic [N_IRQ-1:0] ien_q,
    output logic             irq_o
);

    logic             err_run;
    logic [N_IRQ-1:0] irq_evt;

    assign err_run            = err_set_sw | ovf_evt | merr_evt;
    assign irq_evt[IRQ_READY] = req_go;
    assign irq_evt[IRQ_ABORT] = req_abort;
    assign irq_evt[IRQ_ERROR] = err_run;
    assign irq_o              = |(istate_q & ien_q);

    // busy: set by go, cleared by abort acknowledge or response done
    always_ff @(posedge clk) begin
        if (!rst_n)                      busy_q <= 1'b0;
        else if (abort_ack || resp_done) busy_q <= 1'b0;
        else if (req_go)                 busy_q <= 1'b1;
    end

    // abort flag: set by the system, cleared by the host acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)         abort_q <= 1'b0;
        else if (abort_ack) abort_q <= 1'b0;
        else if (req_abort) abort_q <= 1'b1;
    end

    // error flag: a new error wins over a simultaneous acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)         err_q <= 1'b0;
        else if (err_run)   err_q <= 1'b1;
        else if (abort_ack) err_q <= 1'b0;
    end

    // ready: set when the host finishes a response, cleared by a new go
    always_ff @(posedge clk) begin
        if (!rst_n)         ready_q <= 1'b0;
        else if (resp_done) ready_q <= 1'b1;
        else if (req_go)    ready_q <= 1'b0;
    end

    // system interrupt enable, host read/write
    always_ff @(posedge clk) begin
        if (!rst_n)      sie_q <= 1'b0;
        else if (sie_we) sie_q <= sie_wd;
    end

    // system interrupt status: gated by the enable, write-1-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n)                             sis_q <= 1'b0;
        else if ((err_run || resp_done) && sie_q) sis_q <= 1'b1;
        else if (sis_clr)                       sis_q <= 1'b0;
    end

    // host interrupt enable
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= '0;
        else if (ien_we) ien_q <= ien_wd;
    end

    // host interrupt state, one register per source; set wins over clear
    for (genvar g = 0; g < N_IRQ; g++) begin : g_istate
        always_ff @(posedge clk) begin
            if (!rst_n)                          istate_q[g] <= 1'b0;
            else if (irq_evt[g] || istate_tst[g]) istate_q[g] <= 1'b1;
            else if (istate_clr[g])              istate_q[g] <= 1'b0;
        end
    end

endmodule

// File: rtl/mbx_ctrl.sv
// Mailbox controller top: decodes the host and system register ports,
// connects the inbound write path to the flag logic, returns read data,
// and produces the recoverable alert pulse. Assumes AW <= DW so the base
// and limit registers load from host write data.
module mbx_ctrl
    import mbx_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_req,
    input  logic          h_we,
    input  logic [2:0]    h_addr,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    input  logic          s_req,
    input  logic          s_we,
    input  logic [1:0]    s_addr,
    input  logic [DW-1:0] s_wdata,
    output logic [DW-1:0] s_rdata,
    output logic          m_wr_en,
    output logic [AW-1:0] m_wr_addr,
    output logic [DW-1:0] m_wr_data,
    input  logic          m_wr_err,
    output logic          host_irq,
    output logic          alert_recov
);

    localparam int unsigned WORD_BYTES = DW / 8;

    logic h_wr, s_wr;
    logic base_we, limit_we, push;
    logic ovf_evt, merr_evt;
    logic busy, abort_flag, err_flag, ready, sis, sie;
    logic [N_IRQ-1:0] istate, ien;
    logic [AW-1:0] base, limit, wptr;
    logic alert_q;

    assign h_wr     = h_req & h_we;
    assign s_wr     = s_req & s_we;
    assign base_we  = h_wr && (h_addr == H_INBASE);
    assign limit_we = h_wr && (h_addr == H_INLIMIT);
    assign push     = s_wr && (s_addr == S_WDATA);

    mbx_inbound #(
        .AW   (AW),
        .DW   (DW),
        .STEP (WORD_BYTES)
    ) u_inbound (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_we   (base_we),
        .limit_we  (limit_we),
        .cfg_wd    (h_wdata[AW-1:0]),
        .push      (push),
        .push_data (s_wdata),
        .drop      (err_flag),
        .m_wr_en   (m_wr_en),
        .m_wr_addr (m_wr_addr),
        .m_wr_data (m_wr_data),
        .m_wr_err  (m_wr_err),
        .base_q    (base),
        .limit_q   (limit),
        .wptr_q    (wptr),
        .ovf_evt   (ovf_evt),
        .merr_evt  (merr_evt)
    );

    mbx_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .istate_clr ((h_wr && h_addr == H_ISTATE) ? h_wdata[N_IRQ-1:0] : '0),
        .istate_tst ((h_wr && h_addr == H_ITEST)  ? h_wdata[N_IRQ-1:0] : '0),
        .ien_we     (h_wr && h_addr == H_IEN),
        .ien_wd     (h_wdata[N_IRQ-1:0]),
        .abort_ack  (h_wr && h_addr == H_CTRL && h_wdata[HC_ABORT]),
        .err_set_sw (h_wr && h_addr == H_CTRL && h_wdata[HC_ERROR]),
        .resp_done  (h_wr && h_addr == H_CTRL && h_wdata[HC_DONE]),
        .sie_we     (h_wr && h_addr == H_STATUS),
        .sie_wd     (h_wdata[HS_SIE]),
        .sis_clr    ((h_wr && h_addr == H_STATUS && h_wdata[HS_SIS]) ||
                     (s_wr && s_addr == S_STATUS && s_wdata[SS_INTR])),
        .req_go     (s_wr && s_addr == S_CTRL && s_wdata[SC_GO]),
        .req_abort  (s_wr && s_addr == S_CTRL && s_wdata[SC_ABORT]),
        .ovf_evt    (ovf_evt),
        .merr_evt   (merr_evt),
        .busy_q     (busy),
        .abort_q    (abort_flag),
        .err_q      (err_flag),
        .ready_q    (ready),
        .sis_q      (sis),
        .sie_q      (sie),
        .istate_q   (istate),
        .ien_q      (ien),
        .irq_o      (host_irq)
    );

    // recoverable alert: one-cycle pulse after a refused memory write
    always_ff @(posedge clk) begin
        if (!rst_n) alert_q <= 1'b0;
        else        alert_q <= merr_evt;
    end
    assign alert_recov = alert_q;

    // host read data mux
    always_comb begin
        h_rdata = '0;
        case (h_addr)
            H_ISTATE:  h_rdata = DW'(istate);
            H_IEN:     h_rdata = DW'(ien);
            H_CTRL: begin
                h_rdata[HC_ABORT] = abort_flag;
                h_rdata[HC_ERROR] = err_flag;
            end
            H_STATUS: begin
                h_rdata[HS_BUSY]  = busy;
                h_rdata[HS_SIS]   = sis;
                h_rdata[HS_SIE]   = sie;
                h_rdata[HS_READY] = ready;
            end
            H_INBASE:  h_rdata = DW'(base);
            H_INLIMIT: h_rdata = DW'(limit);
            H_INWPTR:  h_rdata = DW'(wptr);
            default:   h_rdata = '0;
        endcase
    end

    // system read data mux
    always_comb begin
        s_rdata = '0;
        if (s_addr == S_STATUS) begin
            s_rdata[SS_BUSY]  = busy;
            s_rdata[SS_INTR]  = sis;
            s_rdata[SS_ERROR] = err_flag;
            s_rdata[SS_READY] = ready;
        end
    end

endmodule

// File: rtl/mbx_ctrl_chk.sv
// Assertion checker for the mailbox controller, bound into every instance.
module mbx_ctrl_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          m_wr_en,
    input logic          m_wr_err,
    input logic          base_we,
    input logic [AW-1:0] wptr,
    input logic          err_flag,
    input logic          ovf_evt,
    input logic          merr_evt,
    input logic [2:0]    istate,
    input logic          sis,
    input logic          sie,
    input logic          alert_recov
);

    localparam logic [AW-1:0] STEP_A = AW'(4);

    // R9: an accepted word moves the pointer by one word
    a_r9_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wr_en && !m_wr_err && !base_we) |=> (wptr == $past(wptr) + STEP_A));

    // R10: overflow runs the error procedure
    a_r10_ovf_raises_err: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> (err_flag && istate[2]));

    // R11: refused write raises the alert on the following cycle
    a_r11_alert_follows: assert property (@(posedge clk) disable iff (!rst_n)
        merr_evt |=> alert_recov);

    // R11: the alert lasts one cycle
    a_r11_alert_single: assert property (@(posedge clk) disable iff (!rst_n)
        alert_recov |=> !alert_recov);

    // R12: no memory write while the error flag is set
    a_r12_drop_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> !m_wr_en);

    // R6: the system interrupt status only rises when enabled
    a_r6_sis_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sis) |-> $past(sie));

endmodule

bind mbx_ctrl mbx_ctrl_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .m_wr_en     (m_wr_en),
    .m_wr_err    (m_wr_err),
    .base_we     (base_we),
    .wptr        (wptr),
    .err_flag    (err_flag),
    .ovf_evt     (ovf_evt),
    .merr_evt    (merr_evt),
    .istate      (istate),
    .sis         (sis),
    .sie         (sie),
    .alert_recov (alert_recov)
);

// File: tb/mbx_ctrl_bench.sv
module mbx_ctrl_bench;
    import mbx_pkg::*;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_req = 1'b0, h_we = 1'b0;
    logic [2:0]  h_addr = '0;
    logic [31:0] h_wdata = '0, h_rdata;
    logic        s_req = 1'b0, s_we = 1'b0;
    logic [1:0]  s_addr = '0;
    logic [31:0] s_wdata = '0, s_rdata;
    logic        m_wr_en, m_wr_err = 1'b0;
    logic [31:0] m_wr_addr, m_wr_data;
    logic        host_irq, alert_recov;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    mbx_ctrl u_mbx_ctrl (
        .clk, .rst_n, .h_req, .h_we, .h_addr, .h_wdata, .h_rdata,
        .s_req, .s_we, .s_addr, .s_wdata, .s_rdata,
        .m_wr_en, .m_wr_addr, .m_wr_data, .m_wr_err, .host_irq, .alert_recov
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        h_req = 1'b1; h_we = 1'b1; h_addr = a; h_wdata = d;
        @(negedge clk);
        h_req = 1'b0; h_we = 1'b0;
    endtask

    task automatic hr(input logic [2:0] a, output logic [31:0] d);
        h_addr = a;
        #1;
        d = h_rdata;
    endtask

    task automatic sw(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        s_req = 1'b1; s_we = 1'b1; s_addr = a; s_wdata = d;
        @(negedge clk);
        s_req = 1'b0; s_we = 1'b0;
    endtask

    task automatic sr(output logic [31:0] d);
        s_addr = S_STATUS;
        #1;
        d = s_rdata;
    endtask

    task automatic push(input logic [31:0] d, input logic err,
                        output logic en, output logic [31:0] a,
                        output logic [31:0] wd, output logic al);
        @(negedge clk);
        s_req = 1'b1; s_we = 1'b1; s_addr = S_WDATA; s_wdata = d; m_wr_err = err;
        #1;
        en = m_wr_en; a = m_wr_addr; wd = m_wr_data; al = alert_recov;
        @(negedge clk);
        s_req = 1'b0; s_we = 1'b0; m_wr_err = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, a, wd;
        logic en, al;
        logic [31:0] base;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 8; i++) begin
            hr(3'(i), v);
            chk("R1 host reg", v, 32'h0);
        end
        sr(v); chk("R1 sys status", v, 32'h0);
        chk("R1 irq", {31'h0, host_irq}, 32'h0);
        chk("R1 alert", {31'h0, alert_recov}, 32'h0);
        chk("R1 mem wr", {31'h0, m_wr_en}, 32'h0);

        // R2: every enable / state pair, then a partial clear
        for (int en_v = 0; en_v < 8; en_v++) begin
            for (int ts = 0; ts < 8; ts++) begin
                hw(H_ISTATE, 32'h7);
                hw(H_IEN, 32'(en_v));
                hw(H_ITEST, 32'(ts));
                hr(H_ISTATE, v);
                chk("R2 test sets state", v, 32'(ts));
                chk("R2 irq", {31'h0, host_irq}, {31'h0, (en_v & ts) != 0});
                hw(H_ISTATE, 32'h5);
                hr(H_ISTATE, v);
                chk("R2 w1c", v, 32'(ts & 2));
                chk("R2 irq after w1c", {31'h0, host_irq}, {31'h0, (en_v & ts & 2) != 0});
            end
        end
        hw(H_IEN, 32'h0);
        hw(H_ISTATE, 32'h7);

        // R3 / R8: go
        sw(S_CTRL, 32'h2);
        hr(H_STATUS, v); chk("R3 busy", v, 32'h1);
        hr(H_ISTATE, v); chk("R3 ready irq", v, 32'h1);
        sr(v); chk("R8 sys status busy", v, 32'h1);

        // R7 / R6: done without enable
        hw(H_CTRL, 32'h4);
        sr(v); chk("R7 done no sie", v, 32'h8);

        // R8: interrupt field follows sys status not busy
        hw(H_STATUS, 32'h4);
        sw(S_CTRL, 32'h2);
        sr(v); chk("R8 busy without intr", v, 32'h1);
        hw(H_CTRL, 32'h4);
        sr(v); chk("R7 done with sie", v, 32'ha);
        sw(S_STATUS, 32'h2);
        sr(v); chk("R14 sys clear", v, 32'h8);
        sw(S_CTRL, 32'h2);
        hw(H_CTRL, 32'h4);
        hw(H_STATUS, 32'h6);
        hr(H_STATUS, v); chk("R14 host clear", v, 32'hc);
        hw(H_STATUS, 32'h0);
        hw(H_ISTATE, 32'h7);

        // R5 / R6: software error with enable off and on
        for (int sie_v = 0; sie_v < 2; sie_v++) begin
            hw(H_STATUS, 32'(sie_v << 2));
            hw(H_IEN, 32'h4);
            hw(H_CTRL, 32'h2);
            hr(H_CTRL, v); chk("R5 error flag", v, 32'h2);
            hr(H_ISTATE, v); chk("R5 error irq state", v, 32'h4);
            chk("R5 irq", {31'h0, host_irq}, 32'h1);
            hr(H_STATUS, v); chk("R6 sis gating", (v >> 1) & 32'h1, 32'(sie_v));
            sr(v); chk("R8 sys error bit", v & 32'h6, 32'h4 | 32'(sie_v << 1));
            hw(H_CTRL, 32'h1);
            hw(H_STATUS, 32'((sie_v << 2) | 2));
            hw(H_ISTATE, 32'h7);
            hr(H_CTRL, v); chk("R4 ack clears error", v, 32'h0);
        end
        hw(H_IEN, 32'h0);
        hw(H_STATUS, 32'h0);

        // R4: abort and acknowledge
        sw(S_CTRL, 32'h2);
        sw(S_CTRL, 32'h1);
        hr(H_CTRL, v); chk("R4 abort set", v, 32'h1);
        hr(H_ISTATE, v); chk("R4 abort irq", v, 32'h3);
        hw(H_CTRL, 32'h1);
        hr(H_CTRL, v); chk("R4 abort cleared", v, 32'h0);
        hr(H_STATUS, v); chk("R4 busy cleared", v & 32'h1, 32'h0);
        hw(H_ISTATE, 32'h7);

        // R9 / R10 / R12 / R13: limits of zero to four words
        for (int n = 0; n < 5; n++) begin
            base = 32'h100 + 32'h40 * 32'(n);
            hw(H_INLIMIT, base + 32'(4 * n));
            hw(H_INBASE, base);
            hr(H_INWPTR, v); chk("R13 ptr reload", v, base);
            for (int i = 0; i < n; i++) begin
                push(32'ha000_0000 + 32'(n * 16 + i), 1'b0, en, a, wd, al);
                chk("R9 mem write", {31'h0, en}, 32'h1);
                chk("R9 mem addr", a, base + 32'(4 * i));
                chk("R9 mem data", wd, 32'ha000_0000 + 32'(n * 16 + i));
                hr(H_INWPTR, v); chk("R9 ptr step", v, base + 32'(4 * (i + 1)));
            end
            push(32'hdead_0000, 1'b0, en, a, wd, al);
            chk("R10 no write at limit", {31'h0, en}, 32'h0);
            hr(H_CTRL, v); chk("R10 error flag", v, 32'h2);
            hr(H_INWPTR, v); chk("R10 ptr held", v, base + 32'(4 * n));
            hw(H_INLIMIT, base + 32'(4 * n + 8));
            push(32'hdead_0001, 1'b0, en, a, wd, al);
            chk("R12 dropped", {31'h0, en}, 32'h0);
            hr(H_INWPTR, v); chk("R12 ptr held", v, base + 32'(4 * n));
            hw(H_CTRL, 32'h1);
            push(32'hbeef_0000, 1'b0, en, a, wd, al);
            chk("R12 resumes", {31'h0, en}, 32'h1);
            chk("R12 resume addr", a, base + 32'(4 * n));
            hw(H_ISTATE, 32'h7);
        end

        // R11: memory error
        hw(H_STATUS, 32'h4);
        hw(H_INLIMIT, 32'h1000);
        hw(H_INBASE, 32'h800);
        push(32'h1234_5678, 1'b1, en, a, wd, al);
        chk("R11 write issued", {31'h0, en}, 32'h1);
        chk("R11 alert before edge", {31'h0, al}, 32'h0);
        chk("R11 alert pulse", {31'h0, alert_recov}, 32'h1);
        hr(H_INWPTR, v); chk("R11 ptr held", v, 32'h800);
        hr(H_CTRL, v); chk("R11 error flag", v, 32'h2);
        sr(v); chk("R11 sys intr", v & 32'h2, 32'h2);
        hr(H_ISTATE, v); chk("R11 error irq", v & 32'h4, 32'h4);
        @(negedge clk);
        chk("R11 alert one cycle", {31'h0, alert_recov}, 32'h0);

        // R13: base write mid-stream
        hw(H_CTRL, 32'h1);
        push(32'h1, 1'b0, en, a, wd, al);
        hr(H_INWPTR, v); chk("R9 ptr after push", v, 32'h804);
        hw(H_INBASE, 32'h900);
        hr(H_INWPTR, v); chk("R13 ptr reset mid-stream", v, 32'h900);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule